// File: doc/BRIEF.md
# Bus Error Capture and Lock Unit

This block sits next to a memory controller and watches the transactions it completes for two requesters, a processor port and a DMA port. Three error conditions may be raised while a transaction is in progress: a parity fault on the cache tag address, a parity fault on the cache tag control bits, and a reference to memory that does not exist. Any error seen during a transaction turns that transaction's completion code into a hard-error code. The code is returned on the completion lines of the requester that issued the transaction, and only in the cycle after the transaction ends.

The first failing transaction leaves a record: bits 33 down to 5 of its address and the kind of error. The record is then frozen. Further errors still fail their transactions, but they only raise a lost-error flag and leave the record as it was. Software reads the record through a small 16-bit register port. It releases the record by writing ones to the status bits it wants to clear. The record unlocks once every error bit, the lost-error flag included, reads zero.

Top module: `err_cap_unit`

## Requirements
- R1: After reset both completion outputs read idle (processor 3'b000, DMA 2'b00), and every register (select 0 status, 1 address low, 2 address high, 3 reserved) reads 16'h0000.
- R2: A completion code appears only on the port named by `txn_src` (0 processor, 1 DMA). It appears in the cycle after the cycle in which `txn_end` is high and lasts that one cycle. The other port stays idle, and both ports are idle when no transaction ended in the previous cycle.
- R3: An error input raised in any cycle after the previous `txn_end` and up to and including the ending cycle counts against the transaction. An error raised before the end produces no completion code of its own.
- R4: Processor completion codes are 3'b001 for success, 3'b011 for a failed store-conditional (`txn_stc_fail`) and 3'b111 for a hard error. A hard error takes precedence over a store-conditional failure.
- R5: DMA completion codes are 2'b01 for success and 2'b11 for a hard error.
- R6: When an error ends a transaction while the record is unlocked, the address is captured as follows. Select 1 reads address bits 20:5. Select 2 bits 12:0 read address bits 33:21, and its upper bits read zero. Status (select 0) bit 0 is tag address parity, bit 1 is tag control parity and bit 2 is nonexistent memory. All error types seen in that transaction are recorded.
- R7: While any status bit is set, a failing transaction still gets a hard-error code. It sets status bit 15 (lost error) and changes neither the captured address nor status bits 2:0.
- R8: Writing select 0 clears each status bit (2:0 and 15) written as 1 and leaves the bits written as 0. The record stays locked until all four of these bits are zero.
- R9: When a clearing write and a failing transaction end in the same cycle, the clear is applied first. If nothing is left set, the new error is captured in full. Otherwise the error is counted as lost.
- R10: Writes to selects 1, 2 and 3, and to status bits 14:3, change no register. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_end | input | 1 | High in the last cycle of a transaction |
| txn_src | input | 1 | Requester of the ending transaction: 0 processor, 1 DMA |
| txn_addr | input | 34 | Address of the ending transaction |
| txn_stc_fail | input | 1 | Store-conditional of the ending processor transaction failed |
| err_tag_addr | input | 1 | Tag address parity fault seen this cycle |
| err_tag_ctl | input | 1 | Tag control parity fault seen this cycle |
| err_nxm | input | 1 | Nonexistent memory reference seen this cycle |
| cpu_ack | output | 3 | Processor completion code |
| dma_ack | output | 2 | DMA completion code |
| csr_sel | input | 2 | Register select |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 16 | Register write data |
| csr_rdata | output | 16 | Register read data for `csr_sel` |

## Verification
Two events can land on the status register in the same cycle: a software clearing write and a failing transaction end. The bench drives `csr_wr` and `txn_end` together in one cycle with two kinds of write data. One write clears every set bit, so the new error must be captured with its new address and type. The other write leaves a bit set, so only the lost-error bit may rise. A reference model applies the clear first and then the error, and the three registers are read back and compared against it afterwards. The completion code of that same transaction is checked through the scoreboard.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

   localparam int unsigned N_ERR = 3;

   localparam int unsigned ERR_TAG_ADDR = 0;
   localparam int unsigned ERR_TAG_CTL  = 1;
   localparam int unsigned ERR_NXM      = 2;

   typedef enum logic [1:0] {
      CSR_STATUS  = 2'd0,
      CSR_ADDR_LO = 2'd1,
      CSR_ADDR_HI = 2'd2,
      CSR_RSVD    = 2'd3
   } csr_sel_e;

   typedef enum logic {
      SRC_CPU = 1'b0,
      SRC_DMA = 1'b1
   } txn_src_e;

endpackage

// File: rtl/err_pend_acc.sv
module err_pend_acc #(
   parameter int unsigned N_ERR = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txn_end,
   input  logic [N_ERR-1:0] err_in,
   output logic [N_ERR-1:0] err_all
);

   logic [N_ERR-1:0] pend_q;

   // errors of the ending cycle count too
   assign err_all = pend_q | err_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (txn_end) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_q | err_in;
      end
   end

endmodule

// File: rtl/err_ack_enc.sv
module err_ack_enc #(
   parameter int unsigned    ACK_W     = 3,
   parameter logic [ACK_W-1:0] OK_CODE   = 1,
   parameter logic [ACK_W-1:0] STC_CODE  = 3,
   parameter logic [ACK_W-1:0] HARD_CODE = 7,
   parameter bit             HAS_STC   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             hard,
   input  logic             stc_fail,
   output logic [ACK_W-1:0] ack
);

   logic [ACK_W-1:0] code_d;
   logic [ACK_W-1:0] ack_q;

   generate
      if (HAS_STC) begin : g_stc
         always_comb begin
            if (hard)          code_d = HARD_CODE;
            else if (stc_fail) code_d = STC_CODE;
            else               code_d = OK_CODE;
         end
      end else begin : g_plain
         logic unused_stc;
         assign unused_stc = stc_fail;
         always_comb begin
            code_d = hard ? HARD_CODE : OK_CODE;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ack_q <= '0;
      else if (fire)  ack_q <= code_d;
      else            ack_q <= '0;
   end

   assign ack = ack_q;

endmodule

// File: rtl/err_log_bank.sv
module err_log_bank #(
   parameter int unsigned N_ERR = 3,
   parameter int unsigned LOG_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             log_evt,
   input  logic [N_ERR-1:0] err_vec,
   input  logic [LOG_W-1:0] addr_cap,
   input  logic [N_ERR-1:0] clr_err,
   input  logic             clr_lost,
   output logic [N_ERR-1:0] log_err,
   output logic             log_lost,
   output logic [LOG_W-1:0] log_addr
);

   logic [N_ERR-1:0] err_q,  err_left, err_d;
   logic             lost_q, lost_left, lost_d;
   logic [LOG_W-1:0] addr_q, addr_d;
   logic             still_locked;

   // clear first, then judge the lock on what remains
   always_comb begin
      err_left     = err_q & ~clr_err;
      lost_left    = lost_q & ~clr_lost;
      still_locked = (|err_left) | lost_left;
      err_d        = err_left;
      lost_d       = lost_left;
      addr_d       = addr_q;
      if (log_evt) begin
         if (still_locked) begin
            lost_d = 1'b1;
         end else begin
            err_d  = err_vec;
            lost_d = 1'b0;
            addr_d = addr_cap;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= '0;
         lost_q <= 1'b0;
         addr_q <= '0;
      end else begin
         err_q  <= err_d;
         lost_q <= lost_d;
         addr_q <= addr_d;
      end
   end

   assign log_err  = err_q;
   assign log_lost = lost_q;
   assign log_addr = addr_q;

endmodule

// File: rtl/err_csr_view.sv
module err_csr_view #(
   parameter int unsigned N_ERR    = 3,
   parameter int unsigned LOG_W    = 29,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned LOST_BIT = 15
) (
   input  logic [1:0]       csr_sel,
   input  logic [N_ERR-1:0] log_err,
   input  logic             log_lost,
   input  logic [LOG_W-1:0] log_addr,
   output logic [REG_W-1:0] rdata
);
   import err_cap_pkg::*;

   localparam int unsigned HI_W = LOG_W - REG_W;

   logic [REG_W-1:0] stat_w, lo_w, hi_w;

   always_comb begin
      stat_w                = '0;
      stat_w[N_ERR-1:0]     = log_err;
      stat_w[LOST_BIT]      = log_lost;
      lo_w                  = log_addr[REG_W-1:0];
      hi_w                  = '0;
      hi_w[HI_W-1:0]        = log_addr[LOG_W-1:REG_W];
   end

   always_comb begin
      unique case (csr_sel_e'(csr_sel))
         CSR_STATUS:  rdata = stat_w;
         CSR_ADDR_LO: rdata = lo_w;
         CSR_ADDR_HI: rdata = hi_w;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/err_cap_unit.sv
module err_cap_unit #(
   parameter int unsigned ADDR_W    = 34,
   parameter int unsigned LOG_LSB   = 5,
   parameter int unsigned REG_W     = 16,
   parameter int unsigned LOST_BIT  = 15,
   parameter int unsigned CPU_ACK_W = 3,
   parameter int unsigned DMA_ACK_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 txn_end,
   input  logic                 txn_src,
   input  logic [ADDR_W-1:0]    txn_addr,
   input  logic                 txn_stc_fail,
   input  logic                 err_tag_addr,
   input  logic                 err_tag_ctl,
   input  logic                 err_nxm,
   output logic [CPU_ACK_W-1:0] cpu_ack,
   output logic [DMA_ACK_W-1:0] dma_ack,
   input  logic [1:0]           csr_sel,
   input  logic                 csr_wr,
   input  logic [REG_W-1:0]     csr_wdata,
   output logic [REG_W-1:0]     csr_rdata
);
   import err_cap_pkg::*;

   localparam int unsigned LOG_W = ADDR_W - LOG_LSB;

   initial begin
      if (LOG_W <= REG_W || LOG_W > 2 * REG_W)
         $fatal(1, "captured address must span exactly two registers");
      if (LOST_BIT < N_ERR || LOST_BIT >= REG_W)
         $fatal(1, "lost-error bit position out of range");
      if (CPU_ACK_W < 2 || DMA_ACK_W < 2)
         $fatal(1, "completion code width too small");
   end

   logic [N_ERR-1:0] err_now, err_all;
   logic             any_err;
   logic             cpu_fire, dma_fire;
   logic             stat_wr;
   logic [N_ERR-1:0] clr_err;
   logic             clr_lost;
   logic [N_ERR-1:0] log_err;
   logic             log_lost;
   logic [LOG_W-1:0] log_addr;

   always_comb begin
      err_now               = '0;
      err_now[ERR_TAG_ADDR] = err_tag_addr;
      err_now[ERR_TAG_CTL]  = err_tag_ctl;
      err_now[ERR_NXM]      = err_nxm;
   end

   err_pend_acc #(.N_ERR(N_ERR)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .txn_end (txn_end),
      .err_in  (err_now),
      .err_all (err_all)
   );

   assign any_err  = |err_all;
   assign cpu_fire = txn_end && (txn_src == SRC_CPU);
   assign dma_fire = txn_end && (txn_src == SRC_DMA);

   err_ack_enc #(
      .ACK_W     (CPU_ACK_W),
      .OK_CODE   (CPU_ACK_W'(1)),
      .STC_CODE  (CPU_ACK_W'(3)),
      .HARD_CODE ({CPU_ACK_W{1'b1}}),
      .HAS_STC   (1'b1)
   ) u_cpu_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (cpu_fire),
      .hard     (any_err),
      .stc_fail (txn_stc_fail),
      .ack      (cpu_ack)
   );

   err_ack_enc #(
      .ACK_W     (DMA_ACK_W),
      .OK_CODE   (DMA_ACK_W'(1)),
      .STC_CODE  (DMA_ACK_W'(1)),
      .HARD_CODE ({DMA_ACK_W{1'b1}}),
      .HAS_STC   (1'b0)
   ) u_dma_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (dma_fire),
      .hard     (any_err),
      .stc_fail (1'b0),
      .ack      (dma_ack)
   );

   assign stat_wr  = csr_wr && (csr_sel_e'(csr_sel) == CSR_STATUS);
   assign clr_err  = stat_wr ? csr_wdata[N_ERR-1:0] : '0;
   assign clr_lost = stat_wr && csr_wdata[LOST_BIT];

   err_log_bank #(.N_ERR(N_ERR), .LOG_W(LOG_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_evt  (txn_end && any_err),
      .err_vec  (err_all),
      .addr_cap (txn_addr[ADDR_W-1:LOG_LSB]),
      .clr_err  (clr_err),
      .clr_lost (clr_lost),
      .log_err  (log_err),
      .log_lost (log_lost),
      .log_addr (log_addr)
   );

   err_csr_view #(
      .N_ERR    (N_ERR),
      .LOG_W    (LOG_W),
      .REG_W    (REG_W),
      .LOST_BIT (LOST_BIT)
   ) u_view (
      .csr_sel  (csr_sel),
      .log_err  (log_err),
      .log_lost (log_lost),
      .log_addr (log_addr),
      .rdata    (csr_rdata)
   );

   logic unused_bits;
   assign unused_bits = ^{txn_addr[LOG_LSB-1:0], csr_wdata[LOST_BIT-1:N_ERR],
                          csr_wdata[REG_W-1:LOST_BIT]};

endmodule

// File: rtl/err_cap_chk.sv
module err_cap_chk #(
   parameter int unsigned CPU_W = 3,
   parameter int unsigned DMA_W = 2,
   parameter int unsigned LOG_W = 29
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txn_end,
   input logic             txn_src,
   input logic             err_tag_addr,
   input logic             err_tag_ctl,
   input logic             err_nxm,
   input logic [CPU_W-1:0] cpu_ack,
   input logic [DMA_W-1:0] dma_ack,
   input logic [1:0]       csr_sel,
   input logic             csr_wr,
   input logic [2:0]       log_err,
   input logic             log_lost,
   input logic [LOG_W-1:0] log_addr
);

   logic err_in_now, locked, stat_wr;
   assign err_in_now = err_tag_addr | err_tag_ctl | err_nxm;
   assign locked     = (|log_err) | log_lost;
   assign stat_wr    = csr_wr && (csr_sel == 2'd0);

   AST_ACK_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !((|cpu_ack) && (|dma_ack))); // R2

   AST_CPU_ACK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (|cpu_ack) |-> $past(txn_end && !txn_src)); // R2

   AST_DMA_ACK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_ack) |-> $past(txn_end && txn_src)); // R2

   AST_CPU_HARD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_end && !txn_src && err_in_now) |=> (cpu_ack == {CPU_W{1'b1}})); // R4

   AST_DMA_HARD: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_end && txn_src && err_in_now) |=> (dma_ack == {DMA_W{1'b1}})); // R5

   AST_LOCK_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !stat_wr) |=> $stable(log_addr)); // R7

   AST_LOST_ON_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !stat_wr && txn_end && err_in_now) |=> log_lost); // R7

   AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!txn_end && !stat_wr) |=> ($stable(log_err) && $stable(log_lost))); // R8

endmodule

bind err_cap_unit err_cap_chk #(
   .CPU_W (CPU_ACK_W),
   .DMA_W (DMA_ACK_W),
   .LOG_W (LOG_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .txn_end      (txn_end),
   .txn_src      (txn_src),
   .err_tag_addr (err_tag_addr),
   .err_tag_ctl  (err_tag_ctl),
   .err_nxm      (err_nxm),
   .cpu_ack      (cpu_ack),
   .dma_ack      (dma_ack),
   .csr_sel      (csr_sel),
   .csr_wr       (csr_wr),
   .log_err      (log_err),
   .log_lost     (log_lost),
   .log_addr     (log_addr)
);

// File: tb/tb_err_cap_unit.sv
module tb_err_cap_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        txn_end = 1'b0, txn_src = 1'b0, txn_stc_fail = 1'b0;
   logic [33:0] txn_addr = '0;
   logic        err_tag_addr = 1'b0, err_tag_ctl = 1'b0, err_nxm = 1'b0;
   logic [2:0]  cpu_ack;
   logic [1:0]  dma_ack;
   logic [1:0]  csr_sel = 2'd0;
   logic        csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;

   always #10 clk = ~clk;

   err_cap_unit dut (.*);

   typedef struct { logic src; logic [2:0] code; string tag; } exp_t;
   exp_t exp_q[$];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [2:0]  pend = '0, m_err = '0;
   logic        m_lost = 1'b0;
   logic [28:0] m_addr = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] model_reg(input logic [1:0] s);
      case (s)
         2'd0:    return {m_lost, 12'h000, m_err};
         2'd1:    return m_addr[15:0];
         2'd2:    return {3'b000, m_addr[28:16]};
         default: return 16'h0000;
      endcase
   endfunction

   function automatic void model_clear(input logic [15:0] wd);
      m_err = m_err & ~wd[2:0];
      if (wd[15]) m_lost = 1'b0;
   endfunction

   // driver: one ending transaction, optionally with a status write in the same cycle
   task automatic txn(input logic src, input logic [33:0] a, input logic [2:0] e,
                      input logic stc, input logic dw, input logic [15:0] wd, input string tag);
      exp_t x;
      logic [2:0] all;
      @(negedge clk);
      txn_end = 1'b1; txn_src = src; txn_addr = a; txn_stc_fail = stc;
      {err_nxm, err_tag_ctl, err_tag_addr} = e;
      csr_wr = dw; csr_sel = 2'd0; csr_wdata = wd;
      all = pend | e;
      pend = '0;
      x.src = src; x.tag = tag;
      if (src == 1'b0) x.code = (|all) ? 3'b111 : (stc ? 3'b011 : 3'b001);
      else             x.code = (|all) ? 3'b011 : 3'b001;
      exp_q.push_back(x);
      if (dw) model_clear(wd);
      if (|all) begin
         if ((|m_err) || m_lost) m_lost = 1'b1;
         else begin m_err = all; m_lost = 1'b0; m_addr = a[33:5]; end
      end
      @(negedge clk);
      txn_end = 1'b0; txn_stc_fail = 1'b0; csr_wr = 1'b0;
      {err_nxm, err_tag_ctl, err_tag_addr} = 3'b000;
   endtask

   task automatic pulse_err(input logic [2:0] e);
      @(negedge clk);
      {err_nxm, err_tag_ctl, err_tag_addr} = e;
      pend = pend | e;
      @(negedge clk);
      {err_nxm, err_tag_ctl, err_tag_addr} = 3'b000;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] wd);
      @(negedge clk);
      csr_wr = 1'b1; csr_sel = s; csr_wdata = wd;
      if (s == 2'd0) model_clear(wd);
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, input string tag);
      @(negedge clk);
      csr_sel = s;
      #1;
      chk(csr_rdata == model_reg(s), tag, {16'h0, csr_rdata}, {16'h0, model_reg(s)});
   endtask

   task automatic rd_all(input string tag);
      for (int i = 0; i < 4; i++) rd(i[1:0], tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: compares completion codes against the scoreboard queue
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n) begin
            if (exp_q.size() > 0) begin
               exp_t x;
               x = exp_q.pop_front();
               if (x.src == 1'b0)
                  chk(cpu_ack == x.code && dma_ack == 2'b00, x.tag,
                      {27'h0, cpu_ack, dma_ack}, {27'h0, x.code, 2'b00});
               else
                  chk(dma_ack == x.code[1:0] && cpu_ack == 3'b000, x.tag,
                      {27'h0, cpu_ack, dma_ack}, {27'h0, 3'b000, x.code[1:0]});
            end else if (cpu_ack != 3'b000 || dma_ack != 2'b00) begin
               chk(1'b0, "R2/R3 stray completion", {27'h0, cpu_ack, dma_ack}, 32'h0);
            end
         end
      end
   end

   initial begin
      #4_000_000;
      if (!done) begin
         chk(1'b0, "watchdog expired", 32'h0, 32'h1);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cpu_ack == 3'b000 && dma_ack == 2'b00, "R1 idle acks in reset",
          {27'h0, cpu_ack, dma_ack}, 32'h0);
      rst_n = 1'b1;
      rd_all("R1 reset registers");

      txn(1'b0, 34'h0_0000_1000, 3'b000, 1'b0, 1'b0, 16'h0, "R2 R4 cpu ok");
      txn(1'b1, 34'h0_0000_2000, 3'b000, 1'b0, 1'b0, 16'h0, "R2 R5 dma ok");
      txn(1'b0, 34'h0_0000_3000, 3'b000, 1'b1, 1'b0, 16'h0, "R4 cpu stc fail");
      rd_all("R4 no log after clean txns");

      pulse_err(3'b100);
      txn(1'b0, 34'h2_ABCD_EF40, 3'b000, 1'b1, 1'b0, 16'h0, "R3 R4 pending nxm beats stc");
      rd_all("R6 first error captured");

      txn(1'b1, 34'h1_1111_1120, 3'b010, 1'b0, 1'b0, 16'h0, "R5 R7 dma hard while locked");
      rd_all("R7 locked record kept, lost set");

      wr(2'd0, 16'h0004);
      txn(1'b1, 34'h0_5555_5560, 3'b001, 1'b0, 1'b0, 16'h0, "R8 still locked after partial clear");
      rd_all("R8 partial clear keeps lock");

      wr(2'd0, 16'h8000);
      rd_all("R8 full clear");
      wr(2'd1, 16'hFFFF);
      wr(2'd2, 16'hFFFF);
      wr(2'd3, 16'hFFFF);
      wr(2'd0, 16'h7FF8);
      rd_all("R10 ignored writes");

      txn(1'b0, 34'h3_FFFF_FFE0, 3'b011, 1'b0, 1'b0, 16'h0, "R6 cpu two error types");
      rd_all("R6 capture after unlock");

      txn(1'b1, 34'h0_8642_0A60, 3'b100, 1'b0, 1'b1, 16'h0003, "R9 same-cycle full clear");
      rd_all("R9 new error captured");

      txn(1'b1, 34'h1_0000_00A0, 3'b001, 1'b0, 1'b1, 16'h0001, "R9 same-cycle partial clear");
      rd_all("R9 error lost after partial clear");
      rd_all("R10 reads repeat unchanged");

      wr(2'd0, 16'hFFFF);
      txn(1'b0, 34'h0_0000_0020, 3'b000, 1'b0, 1'b0, 16'h0, "R2 R4 ok after clear");
      rd_all("R8 cleared record");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 32'h0);
      done = 1'b1;
      summary();
   end

endmodule